// File: doc/BRIEF.md
# PHY Configuration Write Bridge

This block lets host software update a bank of PHY configuration bytes through a single 32-bit control word. Software writes a 6-bit register index and a data byte into the word and raises a request flag. The block then performs one PHY write after a fixed delay and raises an acknowledge flag. Software must see acknowledge high before it drops the request. The block clears acknowledge only after the request is low, so every write completes a full four-phase handshake.

The configuration file holds 64 entries of 8 bits and sits inside the block. The PHY datapath reads any entry combinationally through a select/value pair. Each internal write is also visible on a one-cycle strobe with its index and byte. The host port is a plain register write enable with a combinational readback. It has no back-pressure, because the handshake flags pace the software. A request raised while acknowledge is still high is refused, and a sticky error flag records it.

Top module: `phy_wr_bridge`

## Requirements
- R1: The control word holds the index in bits [5:0], the byte in bits [15:8], request in bit 24, acknowledge in bit 26 and error in bit 27. Every other bit reads 0, and the index, byte and request read back as last accepted.
- R2: When a host write raises request from 0 to 1 while idle with acknowledge low, the index and byte are taken from that same write and a transaction starts.
- R3: Acknowledge rises exactly 4 clock edges after the edge that accepted the request. The write strobe is high for exactly the one cycle before that, carrying the captured index and byte.
- R4: Once acknowledge is high, the configuration entry at the captured index holds the captured byte, and all other entries are unchanged.
- R5: Acknowledge stays high while request stays high. It falls on the edge after the edge on which request is cleared.
- R6: While a transaction is under way, or while acknowledge is high, host writes to the index and byte fields have no effect.
- R7: If request rises while acknowledge is still high, no transaction starts and the error flag is set.
- R8: Error stays set until a host write with bit 27 at 1 clears it. Host writes never set acknowledge or error directly.
- R9: A synchronous active-high reset clears all configuration entries, the fields, request, acknowledge and error, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host writes the control word this cycle |
| host_wr_data | input | 32 | Control word value written by the host |
| host_rd_data | output | 32 | Control word readback |
| phy_wr_stb | output | 1 | One-cycle PHY write strobe |
| phy_wr_addr | output | 6 | Index of the entry being written |
| phy_wr_data | output | 8 | Byte being written |
| cfg_sel | input | 6 | Entry selected for the PHY datapath |
| cfg_val | output | 8 | Value of the selected entry |

## Verification
The assertions take no fixed handshake order from the host for granted. They hold for any sequence of host writes, including early request drops and requests raised against a high acknowledge. They do assume the host inputs carry no unknown values after reset, and the bench keeps them at defined levels at all times. The stimulus mixes in-protocol random transactions, field disturbances during the busy window and a deliberate back-to-back drop-and-raise. That last case drives the refusal path.

// File: rtl/phy_wr_pkg.sv
package phy_wr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IDX_LSB   = 0;
  localparam int unsigned BYTE_LSB  = 8;
  localparam int unsigned REQ_BIT   = 24;
  localparam int unsigned ACK_BIT   = 26;
  localparam int unsigned ERR_BIT   = 27;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/phy_cfg_file.sv
module phy_cfg_file #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mem_q[g] <= '0;
      end else if (we && (waddr == ADDR_W'(g))) begin
        mem_q[g] <= wdata;
      end
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/phy_wr_ctrl.sv
module phy_wr_ctrl
  import phy_wr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_data
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  hs_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              req_q, ack_q, err_q;

  logic req_rise, start, refuse, fields_open;

  assign req_rise    = wr_en && wr_data[REQ_BIT] && !req_q;
  assign start       = req_rise && (state_q == S_IDLE) && !ack_q;
  assign refuse      = req_rise && ack_q;
  assign fields_open = wr_en && (state_q == S_IDLE) && !ack_q;
  assign phy_we      = (state_q == S_WAIT) && (cnt_q == '0);
  assign phy_addr    = addr_q;
  assign phy_data    = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      req_q  <= 1'b0;
    end else begin
      if (wr_en) req_q <= wr_data[REQ_BIT];
      if (fields_open) begin
        addr_q <= wr_data[IDX_LSB +: ADDR_W];
        data_q <= wr_data[BYTE_LSB +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            state_q <= S_WAIT;
            cnt_q   <= CNT_LOAD;
          end
        end
        S_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= S_ACK;
            ack_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_ACK: begin
          if (!req_q) begin
            state_q <= S_IDLE;
            ack_q   <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (refuse) begin
      err_q <= 1'b1;
    end else if (wr_en && wr_data[ERR_BIT]) begin
      err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[IDX_LSB +: ADDR_W]  = addr_q;
    rd_data[BYTE_LSB +: DATA_W] = data_q;
    rd_data[REQ_BIT] = req_q;
    rd_data[ACK_BIT] = ack_q;
    rd_data[ERR_BIT] = err_q;
  end

  // R3: acknowledge only ever follows a completed PHY write strobe
  a_r3_ack_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(phy_we));
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    phy_we |=> !phy_we);
  // R5: four-phase hold and release
  a_r5_ack_hold: assert property (@(posedge clk) disable iff (rst)
    (ack_q && req_q) |=> ack_q);
  a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_q) |-> !$past(req_q));
  // R6: captured fields frozen while busy
  a_r6_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> ($stable(addr_q) && $stable(data_q)));
  // R7: a request against a high acknowledge never starts a write
  a_r7_refused: assert property (@(posedge clk) disable iff (rst)
    (req_rise && ack_q) |=> (err_q && state_q != S_WAIT));
  // R8: error is sticky until written 1
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_en && wr_data[ERR_BIT])) |=> err_q);
  // R9: reset returns the handshake to idle
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (!ack_q && !err_q && !req_q && state_q == S_IDLE));
endmodule

// File: rtl/phy_wr_bridge.sv
module phy_wr_bridge
  import phy_wr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [31:0]       host_wr_data,
  output logic [31:0]       host_rd_data,
  output logic              phy_wr_stb,
  output logic [ADDR_W-1:0] phy_wr_addr,
  output logic [DATA_W-1:0] phy_wr_data,
  input  logic [ADDR_W-1:0] cfg_sel,
  output logic [DATA_W-1:0] cfg_val
);
  phy_wr_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LATENCY(LATENCY)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr_en),
    .wr_data (host_wr_data),
    .rd_data (host_rd_data),
    .phy_we  (phy_wr_stb),
    .phy_addr(phy_wr_addr),
    .phy_data(phy_wr_data)
  );

  phy_cfg_file #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_file (
    .clk  (clk),
    .rst  (rst),
    .we   (phy_wr_stb),
    .waddr(phy_wr_addr),
    .wdata(phy_wr_data),
    .raddr(cfg_sel),
    .rdata(cfg_val)
  );
endmodule

// File: tb/phy_wr_bridge_bench.sv
module phy_wr_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic [31:0] host_rd_data;
  logic        phy_wr_stb;
  logic [5:0]  phy_wr_addr;
  logic [7:0]  phy_wr_data;
  logic [5:0]  cfg_sel = '0;
  logic [7:0]  cfg_val;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_wr_bridge u_phy_wr_bridge (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .phy_wr_stb(phy_wr_stb), .phy_wr_addr(phy_wr_addr),
    .phy_wr_data(phy_wr_data), .cfg_sel(cfg_sel), .cfg_val(cfg_val)
  );

  function automatic logic [31:0] word(logic err, logic ack, logic req,
                                       logic [7:0] d, logic [5:0] a);
    return {4'b0, err, ack, 1'b0, req, 8'b0, d, 2'b0, a};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [31:0] w);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_wr_data = w;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic check_file(string req);
    for (int i = 0; i < 64; i++) begin
      cfg_sel = 6'(i);
      #1;
      check(req, {24'b0, cfg_val}, {24'b0, model[i]});
    end
  endtask

  // Full transaction: start, optional disturbance, poll, drop, release.
  task automatic txn(logic [5:0] a, logic [7:0] d, bit disturb);
    int cyc;
    int stb_at;
    hwrite(word(1'b0, 1'b0, 1'b1, d, a));
    cyc = 0;
    stb_at = -1;
    if (disturb) begin
      host_wr_en = 1'b1;
      host_wr_data = word(1'b0, 1'b1, 1'b1, ~d, ~a);
    end
    while (cyc < 12) begin
      if (phy_wr_stb) begin
        if (stb_at < 0) stb_at = cyc;
        check("R3 strobe payload", {18'b0, phy_wr_addr, phy_wr_data}, {18'b0, a, d});
      end
      if (host_rd_data[26]) break;
      @(negedge clk);
      host_wr_en = 1'b0;
      cyc++;
    end
    check("R3 ack latency", 32'(cyc), 32'd4);
    check("R3 strobe cycle", 32'(stb_at), 32'd3);
    check("R6 fields held", host_rd_data, word(1'b0, 1'b1, 1'b1, d, a));
    model[a] = d;
    cfg_sel = a;
    #1;
    check("R4 entry written", {24'b0, cfg_val}, {24'b0, d});
    // hold request a while: ack must stay high (R5)
    @(negedge clk);
    check("R5 ack held", {31'b0, host_rd_data[26]}, 32'd1);
    host_wr_en = 1'b1;
    host_wr_data = word(1'b0, 1'b0, 1'b0, 8'h00, 6'h00);
    @(negedge clk);
    host_wr_en = 1'b0;
    check("R5 ack one edge after drop", {31'b0, host_rd_data[26]}, 32'd1);
    @(negedge clk);
    check("R5 ack released", host_rd_data, word(1'b0, 1'b0, 1'b0, d, a));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset word", host_rd_data, 32'h0);
    check_file("R9 reset file");

    // R1: undefined bits read 0, fields read back, ack/err not writable (R8)
    hwrite(32'hFEFF_FFFF & ~32'h0100_0000);
    check("R1 layout readback", host_rd_data, word(1'b0, 1'b0, 1'b0, 8'hFF, 6'h3F));
    check("R8 ack/err not set by write", {30'b0, host_rd_data[27:26]}, 32'd0);
    repeat (3) @(negedge clk);
    check("R1 no spurious ack", {31'b0, host_rd_data[26]}, 32'd0);

    // directed corners R2
    txn(6'h00, 8'hA5, 1'b0);
    txn(6'h3F, 8'h5A, 1'b1);

    // R7: drop and immediately raise while ack is still high
    hwrite(word(1'b0, 1'b0, 1'b1, 8'h11, 6'h05));
    repeat (6) @(negedge clk);
    check("R2 ack up", {31'b0, host_rd_data[26]}, 32'd1);
    model[5] = 8'h11;
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = word(1'b0, 1'b0, 1'b0, 8'h00, 6'h00);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = word(1'b0, 1'b0, 1'b1, 8'h77, 6'h09);
    @(negedge clk);
    host_wr_en = 1'b0;
    check("R7 error set", {31'b0, host_rd_data[27]}, 32'd1);
    repeat (8) @(negedge clk);
    check("R7 no transaction", host_rd_data, word(1'b1, 1'b0, 1'b1, 8'h11, 6'h05));
    check_file("R7 file unchanged");
    hwrite(word(1'b0, 1'b1, 1'b1, 8'h00, 6'h00));
    check("R8 error sticky", {31'b0, host_rd_data[27]}, 32'd1);
    hwrite(word(1'b1, 1'b0, 1'b0, 8'h11, 6'h05));
    check("R8 error cleared", host_rd_data, word(1'b0, 1'b0, 1'b0, 8'h11, 6'h05));

    // random transactions
    for (int n = 0; n < 40; n++) begin
      txn(6'($urandom), 8'($urandom), bit'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    check_file("R4 file after random writes");

    // R9: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    check("R9 word after reset", host_rd_data, 32'h0);
    check_file("R9 file after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule